// File: doc/BRIEF.md
# Multiplier-Free Trivial-Twiddle Radix-2 Butterfly

This element is the final-stage processing element of a radix-2 decimation-in-frequency FFT/IFFT pipeline: the stage whose twiddle factors are only 1 and a quarter turn. Each valid clock it accepts two complex signed samples, `a` and `b`. It forms their sum `a+b` and their difference `a-b`. The sum leaves unchanged. The difference is either passed through or rotated by a quarter turn, and the choice alternates from one valid sample to the next.

No multiplier is used. The rotation exchanges the real and imaginary parts of the difference and negates one of them. Two negate-on-demand add/sub units and two 2-to-1 multiplexers do this work. A mode input picks the direction of the rotation: multiply by -j for the forward transform, or by +j for the inverse.

The alternating select is a local toggle. Reset clears it, and it advances only when a valid sample is accepted. All arithmetic saturates to the sample width.

Top module: `trivial_twiddle_bfly`

## Requirements
- R1: A synchronous active-high reset clears `out_valid` and every data output to zero.
- R2: `out_valid` follows `in_valid` exactly two clocks later, and the data outputs change only when a valid result is emitted.
- R3: The sum outputs equal `a+b` per component, saturated to the signed W-bit range.
- R4: On the even-numbered valid samples after reset (0th, 2nd, ...), the difference outputs equal `a-b` per component, saturated, with no rotation.
- R5: On odd-numbered valid samples with `inverse`=0, the difference `d` is multiplied by -j: the real output is `d.im` and the imaginary output is `-d.re`.
- R6: On odd-numbered valid samples with `inverse`=1, the difference `d` is multiplied by +j: the real output is `-d.im` and the imaginary output is `d.re`.
- R7: Idle cycles, where `in_valid`=0, do not advance the alternating select.
- R8: A sum or difference outside the signed W-bit range clamps to 2^(W-1)-1 or -2^(W-1).
- R9: Negating the most negative value, -2^(W-1), during rotation gives 2^(W-1)-1.
- R10: After any reset, the first valid sample uses the pass-through phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample pair is valid |
| inverse | input | 1 | 0 selects -j rotation (forward), 1 selects +j (inverse) |
| a_re | input | W | Real part of sample a |
| a_im | input | W | Imaginary part of sample a |
| b_re | input | W | Real part of sample b |
| b_im | input | W | Imaginary part of sample b |
| out_valid | output | 1 | Output pair is valid |
| sum_re | output | W | Real part of the sum |
| sum_im | output | W | Imaginary part of the sum |
| dif_re | output | W | Real part of the (possibly rotated) difference |
| dif_im | output | W | Imaginary part of the (possibly rotated) difference |

## Verification
Every result is due exactly two clocks after its inputs are accepted: one register stage holds the butterfly and one holds the rotation. The bench drives a pair on a falling edge and records the expected outputs. Two falling edges later, after both rising edges have passed, it compares the outputs against the recorded values. Idle cycles enter the same queue as entries with no valid flag, so gaps and the alternating phase stay aligned with the design's two-cycle delay.

// File: rtl/ttb_pkg.sv
package ttb_pkg;

  typedef enum logic { PH_PASS = 1'b0, PH_ROT = 1'b1 } phase_e;

  localparam int unsigned LATENCY = 2;

endpackage

// File: rtl/ttb_addsub.sv
module ttb_addsub #(
  parameter int W = 18
) (
  input  logic                neg,
  input  logic signed [W-1:0] x,
  output logic signed [W-1:0] y
);
  localparam logic signed [W:0] MAXV = (W+1)'((1 << (W-1)) - 1);
  localparam logic signed [W:0] MINV = -(W+1)'(1 << (W-1));

  logic signed [W:0] wide;

  always_comb begin
    wide = neg ? ((W+1)'(0) - {x[W-1], x}) : {x[W-1], x};
    if (wide > MAXV)      y = MAXV[W-1:0];
    else if (wide < MINV) y = MINV[W-1:0];
    else                  y = wide[W-1:0];
  end
endmodule

// File: rtl/ttb_phase.sv
module ttb_phase
  import ttb_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   adv,
  output phase_e ph
);
  always_ff @(posedge clk) begin
    if (rst)      ph <= PH_PASS;
    else if (adv) ph <= (ph == PH_PASS) ? PH_ROT : PH_PASS;
  end
endmodule

// File: rtl/ttb_butterfly.sv
module ttb_butterfly
  import ttb_pkg::*;
#(
  parameter int W = 18
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic                inverse,
  input  phase_e              ph_in,
  input  logic signed [W-1:0] a_re,
  input  logic signed [W-1:0] a_im,
  input  logic signed [W-1:0] b_re,
  input  logic signed [W-1:0] b_im,
  output logic                v_q,
  output logic                inv_q,
  output phase_e              ph_q,
  output logic signed [W-1:0] s_re_q,
  output logic signed [W-1:0] s_im_q,
  output logic signed [W-1:0] d_re_q,
  output logic signed [W-1:0] d_im_q
);
  localparam int LANES = 2;
  localparam logic signed [W:0] MAXV = (W+1)'((1 << (W-1)) - 1);
  localparam logic signed [W:0] MINV = -(W+1)'(1 << (W-1));

  function automatic logic signed [W-1:0] clamp(input logic signed [W:0] v);
    if (v > MAXV)      return MAXV[W-1:0];
    else if (v < MINV) return MINV[W-1:0];
    else               return v[W-1:0];
  endfunction

  logic signed [W-1:0] av [LANES];
  logic signed [W-1:0] bv [LANES];
  logic signed [W-1:0] sq [LANES];
  logic signed [W-1:0] dq [LANES];

  assign av[0] = a_re;
  assign av[1] = a_im;
  assign bv[0] = b_re;
  assign bv[1] = b_im;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic signed [W:0] add_w;
    logic signed [W:0] sub_w;
    assign add_w = {av[g][W-1], av[g]} + {bv[g][W-1], bv[g]};
    assign sub_w = {av[g][W-1], av[g]} - {bv[g][W-1], bv[g]};
    always_ff @(posedge clk) begin
      if (rst) begin
        sq[g] <= '0;
        dq[g] <= '0;
      end else if (in_valid) begin
        sq[g] <= clamp(add_w);
        dq[g] <= clamp(sub_w);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q   <= 1'b0;
      inv_q <= 1'b0;
      ph_q  <= PH_PASS;
    end else begin
      v_q <= in_valid;
      if (in_valid) begin
        inv_q <= inverse;
        ph_q  <= ph_in;
      end
    end
  end

  assign s_re_q = sq[0];
  assign s_im_q = sq[1];
  assign d_re_q = dq[0];
  assign d_im_q = dq[1];
endmodule

// File: rtl/ttb_rotator.sv
module ttb_rotator
  import ttb_pkg::*;
#(
  parameter int W = 18
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                v_in,
  input  logic                inv_in,
  input  phase_e              ph_in,
  input  logic signed [W-1:0] s_re,
  input  logic signed [W-1:0] s_im,
  input  logic signed [W-1:0] d_re,
  input  logic signed [W-1:0] d_im,
  output logic                v_out,
  output logic signed [W-1:0] o_s_re,
  output logic signed [W-1:0] o_s_im,
  output logic signed [W-1:0] o_d_re,
  output logic signed [W-1:0] o_d_im
);
  logic signed [W-1:0] im_adj;
  logic signed [W-1:0] re_adj;
  logic signed [W-1:0] mux_re;
  logic signed [W-1:0] mux_im;

  // forward: -j -> (im, -re); inverse: +j -> (-im, re)
  ttb_addsub #(.W(W)) u_neg_im (.neg(inv_in),  .x(d_im), .y(im_adj));
  ttb_addsub #(.W(W)) u_neg_re (.neg(!inv_in), .x(d_re), .y(re_adj));

  assign mux_re = (ph_in == PH_ROT) ? im_adj : d_re;
  assign mux_im = (ph_in == PH_ROT) ? re_adj : d_im;

  always_ff @(posedge clk) begin
    if (rst) begin
      v_out  <= 1'b0;
      o_s_re <= '0;
      o_s_im <= '0;
      o_d_re <= '0;
      o_d_im <= '0;
    end else begin
      v_out <= v_in;
      if (v_in) begin
        o_s_re <= s_re;
        o_s_im <= s_im;
        o_d_re <= mux_re;
        o_d_im <= mux_im;
      end
    end
  end
endmodule

// File: rtl/trivial_twiddle_bfly.sv
module trivial_twiddle_bfly
  import ttb_pkg::*;
#(
  parameter int W = 18
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic                inverse,
  input  logic signed [W-1:0] a_re,
  input  logic signed [W-1:0] a_im,
  input  logic signed [W-1:0] b_re,
  input  logic signed [W-1:0] b_im,
  output logic                out_valid,
  output logic signed [W-1:0] sum_re,
  output logic signed [W-1:0] sum_im,
  output logic signed [W-1:0] dif_re,
  output logic signed [W-1:0] dif_im
);
  phase_e              phase_q;
  logic                v1;
  logic                inv1;
  phase_e              ph1;
  logic signed [W-1:0] s1_re, s1_im, d1_re, d1_im;

  ttb_phase u_phase (
    .clk(clk), .rst(rst), .adv(in_valid), .ph(phase_q)
  );

  ttb_butterfly #(.W(W)) u_bfly (
    .clk(clk), .rst(rst), .in_valid(in_valid), .inverse(inverse),
    .ph_in(phase_q),
    .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im),
    .v_q(v1), .inv_q(inv1), .ph_q(ph1),
    .s_re_q(s1_re), .s_im_q(s1_im), .d_re_q(d1_re), .d_im_q(d1_im)
  );

  ttb_rotator #(.W(W)) u_rot (
    .clk(clk), .rst(rst), .v_in(v1), .inv_in(inv1), .ph_in(ph1),
    .s_re(s1_re), .s_im(s1_im), .d_re(d1_re), .d_im(d1_im),
    .v_out(out_valid),
    .o_s_re(sum_re), .o_s_im(sum_im), .o_d_re(dif_re), .o_d_im(dif_im)
  );
endmodule

// File: rtl/ttb_checker.sv
module ttb_checker #(
  parameter int W = 18
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic                inverse,
  input logic                ph_now,
  input logic signed [W-1:0] a_re,
  input logic signed [W-1:0] a_im,
  input logic signed [W-1:0] b_re,
  input logic signed [W-1:0] b_im,
  input logic                out_valid,
  input logic signed [W-1:0] sum_re,
  input logic signed [W-1:0] dif_re,
  input logic signed [W-1:0] dif_im
);
  localparam logic signed [W:0] MAXV = (W+1)'((1 << (W-1)) - 1);
  localparam logic signed [W:0] MINV = -(W+1)'(1 << (W-1));

  function automatic logic signed [W-1:0] lim(input logic signed [W:0] v);
    if (v > MAXV)      return MAXV[W-1:0];
    else if (v < MINV) return MINV[W-1:0];
    else               return v[W-1:0];
  endfunction

  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst) since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!out_valid && sum_re == '0 && dif_re == '0 && dif_im == '0));

  p_valid_delay_r2: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

  p_sum_sat_r3: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 2'd2 && out_valid) |->
      (sum_re == lim({$past(a_re, 2) > 0 ? 1'b0 : $past(a_re[W-1], 2), $past(a_re, 2)}
                     + {$past(b_re[W-1], 2), $past(b_re, 2)})));

  p_pass_r4: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 2'd2 && out_valid && !$past(ph_now, 2)) |->
      (dif_re == lim({$past(a_re[W-1], 2), $past(a_re, 2)}
                     - {$past(b_re[W-1], 2), $past(b_re, 2)})));

  p_rot_fwd_r5: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 2'd2 && out_valid && $past(ph_now, 2) && !$past(inverse, 2)) |->
      (dif_re == lim({$past(a_im[W-1], 2), $past(a_im, 2)}
                     - {$past(b_im[W-1], 2), $past(b_im, 2)})));

  p_rot_inv_r6: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 2'd2 && out_valid && $past(ph_now, 2) && $past(inverse, 2)) |->
      (dif_im == lim({$past(a_re[W-1], 2), $past(a_re, 2)}
                     - {$past(b_re[W-1], 2), $past(b_re, 2)})));

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!in_valid) |=> $stable(ph_now));
endmodule

bind trivial_twiddle_bfly ttb_checker #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .inverse(inverse),
  .ph_now(phase_q),
  .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im),
  .out_valid(out_valid), .sum_re(sum_re), .dif_re(dif_re), .dif_im(dif_im)
);

// File: tb/trivial_twiddle_bfly_tb.sv
module trivial_twiddle_bfly_tb;
  localparam int W = 18;
  localparam int MAXI = 131071;
  localparam int MINI = -131072;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic inverse = 1'b0;
  logic signed [W-1:0] a_re = '0, a_im = '0, b_re = '0, b_im = '0;
  logic out_valid;
  logic signed [W-1:0] sum_re, sum_im, dif_re, dif_im;

  always #2.5 clk = ~clk;

  trivial_twiddle_bfly #(.W(W)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .inverse(inverse),
    .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im),
    .out_valid(out_valid), .sum_re(sum_re), .sum_im(sum_im),
    .dif_re(dif_re), .dif_im(dif_im)
  );

  typedef struct {
    bit    v;
    int    sr, si, dr, di;
    string ts, td;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  int   ph = 0;
  bit   prev_v = 1'b0;
  bit   done = 1'b0;

  function automatic int sat(input int x);
    if (x > MAXI) return MAXI;
    if (x < MINI) return MINI;
    return x;
  endfunction

  function automatic int rnd();
    return int'($urandom_range(0, 262143)) - 131072;
  endfunction

  task automatic compare();
    exp_t e;
    if (q.size() < 2) return;
    e = q.pop_front();
    checks++;
    if (out_valid !== e.v) begin
      errors++;
      $display("FAIL R2 out_valid actual=%0b expected=%0b", out_valid, e.v);
    end
    if (e.v) begin
      checks++;
      if (int'(sum_re) != e.sr || int'(sum_im) != e.si) begin
        errors++;
        $display("FAIL %s sum actual=(%0d,%0d) expected=(%0d,%0d)",
                 e.ts, sum_re, sum_im, e.sr, e.si);
      end
      checks++;
      if (int'(dif_re) != e.dr || int'(dif_im) != e.di) begin
        errors++;
        $display("FAIL %s dif actual=(%0d,%0d) expected=(%0d,%0d)",
                 e.td, dif_re, dif_im, e.dr, e.di);
      end
    end
  endtask

  task automatic step(input bit v, input bit inv, input int ar, input int ai,
                      input int br, input int bi, input string os = "",
                      input string od = "");
    exp_t e;
    int dr, di;
    @(negedge clk);
    compare();
    rst      = 1'b0;
    in_valid = v;
    inverse  = inv;
    a_re = W'(ar); a_im = W'(ai); b_re = W'(br); b_im = W'(bi);
    e.v = v;
    e.sr = sat(ar + br);
    e.si = sat(ai + bi);
    dr = sat(ar - br);
    di = sat(ai - bi);
    e.ts = (os != "") ? os : "R3";
    if (ph == 0) begin
      e.dr = dr; e.di = di; e.td = "R4";
    end else if (!inv) begin
      e.dr = di; e.di = sat(-dr); e.td = "R5";
    end else begin
      e.dr = sat(-di); e.di = dr; e.td = "R6";
    end
    if (v && !prev_v && od == "") e.td = {e.td, "/R7"};
    if (od != "") e.td = od;
    if (v) ph = 1 - ph;
    prev_v = v;
    q.push_back(e);
  endtask

  task automatic reset_cycle();
    exp_t e;
    @(negedge clk);
    compare();
    rst = 1'b1;
    in_valid = 1'b0;
    e.v = 1'b0; e.sr = 0; e.si = 0; e.dr = 0; e.di = 0; e.ts = "R1"; e.td = "R1";
    q.push_back(e);
    ph = 0;
    prev_v = 1'b0;
  endtask

  initial begin
    repeat (3) reset_cycle();
    // R1: outputs cleared while reset is held
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || sum_re !== '0 || sum_im !== '0 ||
        dif_re !== '0 || dif_im !== '0) begin
      errors++;
      $display("FAIL R1 reset outputs actual=%0b/%0d/%0d/%0d/%0d expected=0",
               out_valid, sum_re, sum_im, dif_re, dif_im);
    end
    q.delete();
    begin
      exp_t e;
      e.v = 1'b0; e.ts = "R1"; e.td = "R1";
      e.sr = 0; e.si = 0; e.dr = 0; e.di = 0;
      q.push_back(e);
    end
    // forward stream, back to back (R4 and R5 alternate)
    for (int i = 0; i < 20; i++) step(1'b1, 1'b0, rnd(), rnd(), rnd(), rnd());
    // inverse stream (R4 and R6 alternate)
    for (int i = 0; i < 20; i++) step(1'b1, 1'b1, rnd(), rnd(), rnd(), rnd());
    // gaps and per-sample mode changes: idle cycles must not advance phase (R7)
    for (int i = 0; i < 30; i++)
      step((i % 3) != 0, (i % 5) > 1, rnd(), rnd(), rnd(), rnd());
    // R8: sum and difference saturation
    step(1'b1, 1'b0, MAXI, MAXI, MAXI, 5, "R8", "");
    step(1'b1, 1'b1, MINI, MINI, MAXI, MAXI, "", "R8");
    // R9: rotate a difference whose parts are the most negative value
    if (ph == 0) step(1'b1, 1'b0, 10, 20, 3, 4);
    step(1'b1, 1'b0, MINI, 7, 0, 0, "", "R9");
    if (ph == 0) step(1'b1, 1'b0, 1, 2, 3, 4);
    step(1'b1, 1'b1, 9, MINI, 0, 0, "", "R9");
    // R10: stop on the rotate phase, then reset and restart
    step(1'b1, 1'b0, 100, 200, 30, 40);
    if (ph == 0) step(1'b1, 1'b0, 5, 6, 7, 8);
    repeat (3) step(1'b0, 1'b0, 0, 0, 0, 0);
    repeat (2) reset_cycle();
    step(1'b1, 1'b0, 1000, -2000, 300, 400, "", "R10");
    step(1'b1, 1'b0, 50, 60, 70, 80);
    repeat (3) step(1'b0, 1'b0, 0, 0, 0, 0);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule